// File: doc/BRIEF.md
# Endpoint Packet Buffer Completion Controller

This block looks after the packet buffer of one USB device endpoint that lives in a shared 3 KB FIFO memory. The FIFO is split into 48 blocks of 64 bytes; the endpoint's region begins at a configured block and spans a configured number of blocks. The block counts the bytes and packets that enter or leave the region. From those counts it decides when the buffer holds a complete unit of work. At that point it raises a buffer-valid flag and, for the completing event, a one-cycle completion pulse.

Two completion modes exist. Single mode treats every packet as one unit of work. Continuous mode is honoured only for bulk endpoints. In this mode max-size packets build up until the whole programmed region is used. A short packet, a zero-length packet or a programmed DMA packet count can end the unit earlier. For an OUT endpoint the buffer turns valid when reception completes and is freed when the reader reports it drained. For an IN endpoint the buffer turns valid when enough bytes have been written or when software forces it, and is freed when transmission completes. The block also exports the byte base address of the region and flags configurations that cannot work.

Top module: `epbuf_cmpl_ctrl`

## Requirements
- R1: `buf_base_addr` equals `cfg_start_blk` multiplied by 64, combinationally.
- R2: `cfg_err` is 1 in any of these cases: `cfg_start_blk` is greater than 47, `cfg_buf_nblk` is 0, start plus block count is greater than 48, or `cfg_cont` is 1 while `cfg_xfer_type` is not 2'b01 (bulk). Otherwise it is 0.
- R3: When `cfg_cont` is 1 but the transfer type is not 2'b01, the block completes exactly as in single mode.
- R4: OUT (`cfg_dir_in`=0), single mode, buffer not valid: a `pkt_end` strobe makes `buf_valid` 1 and gives a `cmpl_pulse` in the following cycle. This holds for a full-size packet, a short packet and a zero-length packet.
- R5: OUT, continuous mode: reception completes on the packet that brings the accumulated byte count to at least `cfg_buf_nblk`×64.
- R6: OUT, continuous mode: a packet with `pkt_short`=1, including one with `pkt_len`=0, completes reception whatever the count.
- R7: OUT, continuous mode: when `dma_pkt_cnt` is nonzero, reception completes on the packet whose ordinal equals it. A value of 0 disables this rule.
- R8: OUT with the buffer valid: `pkt_end` is ignored and `buf_valid` holds until `rd_drained`. `rd_drained` clears `buf_valid` in the next cycle and resets the counters, so the next buffer accumulates from zero.
- R9: IN (`cfg_dir_in`=1), single mode: the buffer becomes valid the cycle after the `wr_byte` that brings the written count to `cfg_max_pkt`.
- R10: IN, continuous mode: the buffer becomes valid the cycle after the `wr_byte` that brings the written count to `cfg_buf_nblk`×64.
- R11: IN, buffer not valid: `sw_valid_set` makes `buf_valid` 1 in the next cycle with whatever byte count is present, including zero.
- R12: IN with the buffer valid: in single mode any `pkt_end` completes transmission. In continuous mode completion comes from a `pkt_end` with `pkt_short`=1 or from one that brings the sent total to at least the written count. Completion clears `buf_valid`, gives a `cmpl_pulse` and resets the counters.
- R13: `cmpl_pulse` is never high for two cycles in a row. `wr_byte` while an IN buffer is valid and `pkt_end` while an IN buffer is not valid have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_xfer_type | input | 2 | Transfer type; 2'b01 is bulk |
| cfg_dir_in | input | 1 | 1 = IN (device transmits), 0 = OUT |
| cfg_cont | input | 1 | Continuous (multi-packet) mode request |
| cfg_max_pkt | input | MPS_W | Max packet size in bytes |
| cfg_buf_nblk | input | BLK_W | Buffer size in 64-byte blocks |
| cfg_start_blk | input | BLK_W | First block of the buffer region |
| dma_pkt_cnt | input | DMA_W | OUT packet count that ends a continuous buffer; 0 = unused |
| pkt_end | input | 1 | Strobe: a packet finished on the bus |
| pkt_short | input | 1 | The finishing packet was short or zero-length |
| pkt_len | input | MPS_W | Byte length of the finishing packet |
| wr_byte | input | 1 | Strobe: one byte written into an IN buffer |
| sw_valid_set | input | 1 | Software forces an IN buffer valid |
| rd_drained | input | 1 | Strobe: reader emptied a valid OUT buffer |
| buf_valid | output | 1 | Buffer holds a completed unit |
| cmpl_pulse | output | 1 | One-cycle completion indication |
| buf_base_addr | output | BLK_W+6 | Byte base address of the region |
| cfg_err | output | 1 | Configuration cannot be honoured |

## Verification
The bench targets the exact packet or byte on which each threshold fires. A counter compared with the wrong relation would complete one packet early or late. A design that forgot the bulk-only qualification would keep aggregating on an interrupt endpoint, and the R3 scenario catches that. The DMA rule is run with a count smaller than the byte limit and also with 0, so a design that ignores it or treats 0 as a live value stands out. After each drain or transmit completion the next buffer must again need its full quota, which exposes counters that are not cleared. The bench also sends strobes in the wrong phase, such as writes into a valid IN buffer or packets into a held OUT buffer, to catch logic that lets them leak into the counts.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;

    // FIFO geometry: 64-byte blocks, 48 of them (3 KB)
    localparam int BLK_LOG2    = 6;
    localparam int FIFO_BLOCKS = 48;

    typedef enum logic [1:0] {
        XT_CONTROL = 2'b00,
        XT_BULK    = 2'b01,
        XT_INTR    = 2'b10,
        XT_ISOCH   = 2'b11
    } xfer_kind_t;

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_HELD = 1'b1
    } buf_phase_t;

    // One cycle's worth of decisions from the completion logic
    typedef struct packed {
        logic clr;        // reset all counters
        logic add_rx;     // count a received packet and its bytes
        logic add_wr;     // count one written byte
        logic add_tx;     // count a transmitted packet and its bytes
        logic set_valid;
        logic clr_valid;
        logic pulse;
    } epbuf_ctl_t;

    function automatic logic is_bulk(input logic [1:0] kind);
        return xfer_kind_t'(kind) == XT_BULK;
    endfunction

    function automatic logic span_fits(input int start_blk, input int nblk);
        return (start_blk < FIFO_BLOCKS) && (nblk != 0) &&
               (start_blk + nblk <= FIFO_BLOCKS);
    endfunction

endpackage

// File: rtl/epbuf_region.sv
module epbuf_region
    import epbuf_pkg::*;
#(
    parameter int BLK_W  = 6,
    parameter int ADDR_W = BLK_W + BLK_LOG2,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic [1:0]        xfer_type,
    input  logic              cont_req,
    input  logic [BLK_W-1:0]  start_blk,
    input  logic [BLK_W-1:0]  nblk,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  buf_bytes,
    output logic              eff_cont,
    output logic              cfg_err
);
    logic bulk;
    logic fits;

    assign bulk      = is_bulk(xfer_type);
    assign fits      = span_fits(int'(start_blk), int'(nblk));
    assign base_addr = {start_blk, {BLK_LOG2{1'b0}}};
    assign buf_bytes = {1'b0, nblk, {BLK_LOG2{1'b0}}};

    // Continuous aggregation only exists for bulk endpoints
    assign eff_cont  = cont_req && bulk;
    assign cfg_err   = !fits || (cont_req && !bulk);
endmodule

// File: rtl/epbuf_counters.sv
module epbuf_counters
    import epbuf_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter int LEN_W = 11,
    parameter int DMA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  epbuf_ctl_t        ctl,
    input  logic [LEN_W-1:0]  pkt_len,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic [DMA_W-1:0]  pkt_cnt,
    output logic [CNT_W-1:0]  sent_cnt
);
    logic [CNT_W-1:0] len_ext;
    assign len_ext = CNT_W'(pkt_len);

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            byte_cnt <= '0;
            pkt_cnt  <= '0;
            sent_cnt <= '0;
        end else begin
            if (ctl.add_rx)
                byte_cnt <= byte_cnt + len_ext;
            else if (ctl.add_wr)
                byte_cnt <= byte_cnt + CNT_W'(1);
            if (ctl.add_rx || ctl.add_tx)
                pkt_cnt <= pkt_cnt + DMA_W'(1);
            if (ctl.add_tx)
                sent_cnt <= sent_cnt + len_ext;
        end
    end
endmodule

// File: rtl/epbuf_decide.sv
module epbuf_decide
    import epbuf_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter int LEN_W = 11,
    parameter int DMA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_in,
    input  logic              eff_cont,
    input  logic [LEN_W-1:0]  max_pkt,
    input  logic [CNT_W-1:0]  buf_bytes,
    input  logic [DMA_W-1:0]  dma_cnt,
    input  logic              pkt_end,
    input  logic              pkt_short,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              wr_byte,
    input  logic              sw_valid_set,
    input  logic              rd_drained,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic [DMA_W-1:0]  pkt_cnt,
    input  logic [CNT_W-1:0]  sent_cnt,
    output epbuf_ctl_t        ctl,
    output logic              buf_valid,
    output logic              cmpl_pulse
);
    buf_phase_t       phase;
    logic [CNT_W-1:0] rx_total;
    logic [CNT_W-1:0] wr_total;
    logic [CNT_W-1:0] tx_total;
    logic [CNT_W-1:0] in_thresh;
    logic [DMA_W:0]   pkt_next;
    logic             dma_hit;
    logic             rx_done;
    logic             tx_done;

    assign rx_total  = byte_cnt + CNT_W'(pkt_len);
    assign wr_total  = byte_cnt + CNT_W'(1);
    assign tx_total  = sent_cnt + CNT_W'(pkt_len);
    assign in_thresh = eff_cont ? buf_bytes : CNT_W'(max_pkt);
    assign pkt_next  = {1'b0, pkt_cnt} + (DMA_W+1)'(1);
    assign dma_hit   = (dma_cnt != '0) && (pkt_next == {1'b0, dma_cnt});

    // Single mode: each packet is a unit of work
    assign rx_done = !eff_cont || pkt_short || (rx_total >= buf_bytes) || dma_hit;
    assign tx_done = !eff_cont || pkt_short || (tx_total >= byte_cnt);

    always_comb begin
        ctl = '0;
        unique case ({dir_in, phase})
            {1'b0, PH_FILL}: begin
                if (pkt_end) begin
                    ctl.add_rx = 1'b1;
                    if (rx_done) begin
                        ctl.set_valid = 1'b1;
                        ctl.pulse     = 1'b1;
                    end
                end
            end
            {1'b0, PH_HELD}: begin
                if (rd_drained) begin
                    ctl.clr_valid = 1'b1;
                    ctl.clr       = 1'b1;
                end
            end
            {1'b1, PH_FILL}: begin
                if (wr_byte) begin
                    ctl.add_wr = 1'b1;
                    if (wr_total >= in_thresh)
                        ctl.set_valid = 1'b1;
                end
                if (sw_valid_set)
                    ctl.set_valid = 1'b1;
            end
            default: begin
                if (pkt_end) begin
                    if (tx_done) begin
                        ctl.clr       = 1'b1;
                        ctl.clr_valid = 1'b1;
                        ctl.pulse     = 1'b1;
                    end else begin
                        ctl.add_tx = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_FILL;
            cmpl_pulse <= 1'b0;
        end else begin
            cmpl_pulse <= ctl.pulse;
            if (ctl.set_valid)
                phase <= PH_HELD;
            else if (ctl.clr_valid)
                phase <= PH_FILL;
        end
    end

    assign buf_valid = (phase == PH_HELD);
endmodule

// File: rtl/epbuf_cmpl_ctrl.sv
module epbuf_cmpl_ctrl
    import epbuf_pkg::*;
#(
    parameter int MPS_W = 11,
    parameter int BLK_W = 6,
    parameter int DMA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                cfg_xfer_type,
    input  logic                      cfg_dir_in,
    input  logic                      cfg_cont,
    input  logic [MPS_W-1:0]          cfg_max_pkt,
    input  logic [BLK_W-1:0]          cfg_buf_nblk,
    input  logic [BLK_W-1:0]          cfg_start_blk,
    input  logic [DMA_W-1:0]          dma_pkt_cnt,
    input  logic                      pkt_end,
    input  logic                      pkt_short,
    input  logic [MPS_W-1:0]          pkt_len,
    input  logic                      wr_byte,
    input  logic                      sw_valid_set,
    input  logic                      rd_drained,
    output logic                      buf_valid,
    output logic                      cmpl_pulse,
    output logic [BLK_W+BLK_LOG2-1:0] buf_base_addr,
    output logic                      cfg_err
);
    localparam int ADDR_W = BLK_W + BLK_LOG2;
    localparam int CNT_W  = ADDR_W + 1;

    logic [CNT_W-1:0] buf_bytes;
    logic             eff_cont;
    logic [CNT_W-1:0] byte_cnt;
    logic [CNT_W-1:0] sent_cnt;
    logic [DMA_W-1:0] pkt_cnt;
    epbuf_ctl_t       ctl;

    epbuf_region #(
        .BLK_W (BLK_W),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_region (
        .xfer_type(cfg_xfer_type),
        .cont_req (cfg_cont),
        .start_blk(cfg_start_blk),
        .nblk     (cfg_buf_nblk),
        .base_addr(buf_base_addr),
        .buf_bytes(buf_bytes),
        .eff_cont (eff_cont),
        .cfg_err  (cfg_err)
    );

    epbuf_counters #(
        .CNT_W(CNT_W),
        .LEN_W(MPS_W),
        .DMA_W(DMA_W)
    ) u_counters (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .pkt_len (pkt_len),
        .byte_cnt(byte_cnt),
        .pkt_cnt (pkt_cnt),
        .sent_cnt(sent_cnt)
    );

    epbuf_decide #(
        .CNT_W(CNT_W),
        .LEN_W(MPS_W),
        .DMA_W(DMA_W)
    ) u_decide (
        .clk         (clk),
        .rst         (rst),
        .dir_in      (cfg_dir_in),
        .eff_cont    (eff_cont),
        .max_pkt     (cfg_max_pkt),
        .buf_bytes   (buf_bytes),
        .dma_cnt     (dma_pkt_cnt),
        .pkt_end     (pkt_end),
        .pkt_short   (pkt_short),
        .pkt_len     (pkt_len),
        .wr_byte     (wr_byte),
        .sw_valid_set(sw_valid_set),
        .rd_drained  (rd_drained),
        .byte_cnt    (byte_cnt),
        .pkt_cnt     (pkt_cnt),
        .sent_cnt    (sent_cnt),
        .ctl         (ctl),
        .buf_valid   (buf_valid),
        .cmpl_pulse  (cmpl_pulse)
    );
endmodule

// File: rtl/epbuf_cmpl_chk.sv
module epbuf_cmpl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_xfer_type,
    input logic       cfg_dir_in,
    input logic       cfg_cont,
    input logic       sw_valid_set,
    input logic       rd_drained,
    input logic       buf_valid,
    input logic       cmpl_pulse,
    input logic       cfg_err
);
    // R13: completion indication lasts a single cycle
    p_pulse_once_r13: assert property (@(posedge clk) disable iff (rst)
        cmpl_pulse |=> !cmpl_pulse);

    // R12 (and R4): every completion coincides with a change of the valid flag
    p_pulse_moves_valid_r12: assert property (@(posedge clk) disable iff (rst)
        cmpl_pulse |-> (buf_valid != $past(buf_valid)));

    // R8: a held OUT buffer stays held until drained
    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_dir_in && buf_valid && !rd_drained) |=> buf_valid);

    // R8: drain frees a held OUT buffer
    p_drain_frees_r8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_dir_in && buf_valid && rd_drained) |=> !buf_valid);

    // R11: software valid request takes effect next cycle
    p_sw_valid_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_dir_in && !buf_valid && sw_valid_set) |=> buf_valid);

    // R2: continuous request on a non-bulk endpoint is a configuration error
    p_nonbulk_cont_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_cont && cfg_xfer_type != 2'b01) |-> cfg_err);
endmodule

bind epbuf_cmpl_ctrl epbuf_cmpl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_xfer_type(cfg_xfer_type),
    .cfg_dir_in   (cfg_dir_in),
    .cfg_cont     (cfg_cont),
    .sw_valid_set (sw_valid_set),
    .rd_drained   (rd_drained),
    .buf_valid    (buf_valid),
    .cmpl_pulse   (cmpl_pulse),
    .cfg_err      (cfg_err)
);

// File: tb/tb_epbuf_cmpl_ctrl.sv
module tb_epbuf_cmpl_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_xfer_type = 2'b01;
    logic        cfg_dir_in = 1'b0;
    logic        cfg_cont = 1'b0;
    logic [10:0] cfg_max_pkt = 11'd64;
    logic [5:0]  cfg_buf_nblk = 6'd1;
    logic [5:0]  cfg_start_blk = 6'd0;
    logic [7:0]  dma_pkt_cnt = 8'd0;
    logic        pkt_end = 1'b0;
    logic        pkt_short = 1'b0;
    logic [10:0] pkt_len = 11'd0;
    logic        wr_byte = 1'b0;
    logic        sw_valid_set = 1'b0;
    logic        rd_drained = 1'b0;
    logic        buf_valid;
    logic        cmpl_pulse;
    logic [11:0] buf_base_addr;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model state
    bit    m_valid;
    bit    m_pulse;
    int    m_bytes, m_pkts, m_sent;
    string m_tag;

    always #4 clk = ~clk;   // 125 MHz

    epbuf_cmpl_ctrl dut (
        .clk(clk), .rst(rst), .cfg_xfer_type(cfg_xfer_type), .cfg_dir_in(cfg_dir_in),
        .cfg_cont(cfg_cont), .cfg_max_pkt(cfg_max_pkt), .cfg_buf_nblk(cfg_buf_nblk),
        .cfg_start_blk(cfg_start_blk), .dma_pkt_cnt(dma_pkt_cnt), .pkt_end(pkt_end),
        .pkt_short(pkt_short), .pkt_len(pkt_len), .wr_byte(wr_byte),
        .sw_valid_set(sw_valid_set), .rd_drained(rd_drained), .buf_valid(buf_valid),
        .cmpl_pulse(cmpl_pulse), .buf_base_addr(buf_base_addr), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_err();
        int s = int'(cfg_start_blk);
        int n = int'(cfg_buf_nblk);
        return (s > 47) || (n == 0) || (s + n > 48) || (cfg_cont && cfg_xfer_type != 2'b01);
    endfunction

    task automatic model_step();
        int  bufb = int'(cfg_buf_nblk) * 64;
        bit  cont = cfg_cont && (cfg_xfer_type == 2'b01);
        int  len  = int'(pkt_len);
        m_pulse = 1'b0;
        m_tag   = "R13";
        if (!cfg_dir_in) begin
            if (!m_valid) begin
                if (pkt_end) begin
                    int  nb = m_bytes + len;
                    int  np = m_pkts + 1;
                    bit  dh = (dma_pkt_cnt != 0) && (np == int'(dma_pkt_cnt));
                    bit  dn;
                    if (!cont) begin
                        dn = 1'b1;
                        m_tag = cfg_cont ? "R3" : "R4";
                    end else begin
                        dn = pkt_short || (nb >= bufb) || dh;
                        m_tag = pkt_short ? "R6" : (nb >= bufb) ? "R5" : dh ? "R7" : "R5";
                    end
                    m_bytes = nb;
                    m_pkts  = np % 256;
                    if (dn) begin
                        m_valid = 1'b1;
                        m_pulse = 1'b1;
                    end
                end
            end else begin
                m_tag = "R8";
                if (rd_drained) begin
                    m_valid = 1'b0;
                    m_bytes = 0; m_pkts = 0; m_sent = 0;
                end
            end
        end else begin
            if (!m_valid) begin
                int thr = cont ? bufb : int'(cfg_max_pkt);
                if (wr_byte) begin
                    m_bytes++;
                    m_tag = cont ? "R10" : "R9";
                    if (m_bytes >= thr) m_valid = 1'b1;
                end
                if (sw_valid_set) begin
                    m_valid = 1'b1;
                    m_tag = "R11";
                end
            end else begin
                if (pkt_end) begin
                    int ns = m_sent + len;
                    m_tag = "R12";
                    if (!cont || pkt_short || ns >= m_bytes) begin
                        m_valid = 1'b0;
                        m_pulse = 1'b1;
                        m_bytes = 0; m_pkts = 0; m_sent = 0;
                    end else begin
                        m_sent = ns;
                        m_pkts = (m_pkts + 1) % 256;
                    end
                end
            end
        end
    endtask

    // called at a falling edge; drives strobes, lets one rising edge pass, compares
    task automatic cyc(input bit pe, input bit ps, input int len,
                       input bit wr, input bit sw, input bit dr);
        pkt_end = pe; pkt_short = ps; pkt_len = 11'(len);
        wr_byte = wr; sw_valid_set = sw; rd_drained = dr;
        model_step();
        @(negedge clk);
        check(m_tag, "buf_valid", int'(buf_valid), int'(m_valid));
        check(m_tag, "cmpl_pulse", int'(cmpl_pulse), int'(m_pulse));
        pkt_end = 1'b0; pkt_short = 1'b0; pkt_len = '0;
        wr_byte = 1'b0; sw_valid_set = 1'b0; rd_drained = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_valid = 1'b0; m_pulse = 1'b0;
        m_bytes = 0; m_pkts = 0; m_sent = 0;
        check("R13", "reset buf_valid", int'(buf_valid), 0);
        check("R13", "reset cmpl_pulse", int'(cmpl_pulse), 0);
    endtask

    task automatic set_cfg(input logic [1:0] t, input bit din, input bit c, input int mps,
                           input int nb, input int sb, input int dma);
        cfg_xfer_type = t; cfg_dir_in = din; cfg_cont = c; cfg_max_pkt = 11'(mps);
        cfg_buf_nblk = 6'(nb); cfg_start_blk = 6'(sb); dma_pkt_cnt = 8'(dma);
    endtask

    task automatic region_check(input int sb, input int nb, input bit c, input logic [1:0] t);
        set_cfg(t, 1'b0, c, 64, nb, sb, 0);
        #1;
        check("R1", "base address", int'(buf_base_addr), sb * 64);
        check("R2", "cfg_err", int'(cfg_err), int'(exp_err()));
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        @(negedge clk);
        do_reset();

        // R1 / R2 region corners
        region_check(0, 1, 1'b0, 2'b01);
        region_check(47, 1, 1'b0, 2'b01);
        region_check(47, 2, 1'b0, 2'b01);
        region_check(48, 1, 1'b0, 2'b01);
        region_check(10, 0, 1'b0, 2'b01);
        region_check(40, 8, 1'b1, 2'b01);
        region_check(40, 8, 1'b1, 2'b10);
        region_check(63, 1, 1'b0, 2'b11);

        // R3: continuous request on interrupt type behaves as single
        set_cfg(2'b10, 1'b0, 1'b1, 64, 4, 0, 0);
        do_reset();
        cyc(1, 0, 64, 0, 0, 0);
        check("R3", "non-bulk completes on first packet", int'(buf_valid), 1);
        cyc(0, 0, 0, 0, 0, 1);

        // R4: single OUT with a zero-length packet
        set_cfg(2'b01, 1'b0, 1'b0, 64, 4, 2, 0);
        do_reset();
        cyc(1, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);

        // R5: continuous OUT, two max packets fill 128 bytes
        set_cfg(2'b01, 1'b0, 1'b1, 64, 2, 4, 0);
        do_reset();
        cyc(1, 0, 64, 0, 0, 0);
        check("R5", "no completion after first of two", int'(buf_valid), 0);
        cyc(1, 0, 64, 0, 0, 0);
        check("R5", "completion on second packet", int'(cmpl_pulse), 1);
        // R8: packet while held is ignored, drain, and next buffer needs both again
        cyc(1, 0, 64, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(1, 0, 64, 0, 0, 0);
        check("R8", "restart from zero after drain", int'(buf_valid), 0);
        cyc(1, 0, 64, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);

        // R6: short then zero-length in continuous mode
        cyc(1, 1, 10, 0, 0, 0);
        check("R6", "short packet completes", int'(buf_valid), 1);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);

        // R7: DMA count 3 under a 256-byte buffer of 32-byte packets
        set_cfg(2'b01, 1'b0, 1'b1, 32, 4, 8, 3);
        do_reset();
        cyc(1, 0, 32, 0, 0, 0);
        cyc(1, 0, 32, 0, 0, 0);
        check("R7", "no completion before count", int'(buf_valid), 0);
        cyc(1, 0, 32, 0, 0, 0);
        check("R7", "completion on third packet", int'(cmpl_pulse), 1);
        cyc(0, 0, 0, 0, 0, 1);

        // R9: single IN, 8-byte max
        set_cfg(2'b01, 1'b1, 1'b0, 8, 1, 0, 0);
        do_reset();
        for (int i = 0; i < 7; i++) cyc(0, 0, 0, 1, 0, 0);
        check("R9", "not valid at 7 bytes", int'(buf_valid), 0);
        cyc(1, 0, 8, 1, 0, 0);
        check("R9", "valid at 8 bytes", int'(buf_valid), 1);
        cyc(0, 0, 0, 1, 0, 0);   // R13: write into valid buffer ignored
        cyc(1, 0, 8, 0, 0, 0);
        check("R12", "single IN done", int'(buf_valid), 0);

        // R10 / R12: continuous IN, 64 bytes in 16-byte packets
        set_cfg(2'b01, 1'b1, 1'b1, 16, 1, 5, 0);
        do_reset();
        for (int i = 0; i < 64; i++) cyc(0, 0, 0, 1, 0, 0);
        check("R10", "valid after buffer size", int'(buf_valid), 1);
        for (int i = 0; i < 4; i++) cyc(1, 0, 16, 0, 0, 0);
        check("R12", "freed after fourth packet", int'(buf_valid), 0);

        // R11: software valid with 3 bytes, then short transmit
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 0);
        check("R11", "forced valid", int'(buf_valid), 1);
        cyc(1, 1, 3, 0, 0, 0);
        // R11: zero-length forced
        cyc(0, 0, 0, 0, 1, 0);
        cyc(1, 1, 0, 0, 0, 0);

        // constrained random episodes
        for (int ep = 0; ep < 40; ep++) begin
            bit din = 1'($urandom_range(0, 1));
            logic [1:0] t = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b01;
            bit c = 1'($urandom_range(0, 3) != 0);
            int mps;
            int nb = int'($urandom_range(1, 4));
            int sb = int'($urandom_range(0, 48 - nb));
            int dma = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, 6)) : 0;
            case ($urandom_range(0, 3))
                0: mps = 8;
                1: mps = 16;
                2: mps = 32;
                default: mps = 64;
            endcase
            set_cfg(t, din, c, mps, nb, sb, dma);
            do_reset();
            #1;
            check("R1", "random base", int'(buf_base_addr), sb * 64);
            check("R2", "random cfg_err", int'(cfg_err), int'(exp_err()));
            for (int k = 0; k < 400; k++) begin
                bit sh = ($urandom_range(0, 4) == 0);
                int ln = sh ? int'($urandom_range(0, mps - 1)) : mps;
                bit pe = ($urandom_range(0, 2) == 0);
                if (!din)
                    cyc(pe, sh, ln, 0, 0, $urandom_range(0, 3) == 0);
                else
                    cyc(pe, sh, ln, $urandom_range(0, 3) != 0, $urandom_range(0, 59) == 0, 0);
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule